// File: doc/BRIEF.md
# HDLC Receive Deframer

This block turns a serial HDLC bit stream into frame bytes. One line bit is taken on each cycle in which the bit-clock enable is high. While receive is enabled, the block looks for the flag octet and, once it holds flag sync, removes the stuffed zeros the transmitter inserted. Each run of eight data bits becomes a byte, taken least significant bit first. Bytes come out on a one-cycle valid strobe. The first byte of a frame carries an address marker and the final data byte carries an end marker.

The two frame check octets are held back through a short holding line and never appear on the byte output. At the closing flag, the CRC-CCITT residue over all frame bytes is compared with the good-frame constant. A single-cycle completion strobe then reports the frame as good, bad or aborted.

A run of seven ones drops flag sync, and so does a software hunt command. Bytes already delivered stay delivered. Back-to-back flags produce no frame.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After reset, and whenever receive is enabled but no flag has yet been seen, `hunt` is 1. The sampling edge of the last bit of a flag (0,1,1,1,1,1,1,0 on the line) clears `hunt` to 0.
- R2: While in sync, a 0 that follows exactly five consecutive 1 bits is deleted and does not count as a data bit.
- R3: Data bits are packed least significant bit first into bytes, and each byte is presented with a one-cycle `byte_valid`. The last two bytes before the closing flag are the frame check sequence and are never presented.
- R4: `byte_first` is 1 on the first byte presented for a frame and only there. `byte_last` is 1 only on the final data byte, which is presented together with the closing flag.
- R5: At a closing flag the status is good (`frame_status` = 0) only if all three hold: the CRC-CCITT register, preset to 0xFFFF and run over all received bytes, equals 0xF0B8; at least four bytes arrived; and the flag is byte aligned.
- R6: `frame_done` and the status are presented for one cycle, one clock after the sampling edge of the closing flag's last bit.
- R7: A flag that follows a flag with no complete byte between them produces no `frame_done` and no byte.
- R8: A frame whose check sequence does not give the residue is reported bad (`frame_status` = 1). Its data bytes are still presented.
- R9: A frame with fewer than four bytes, or whose closing flag is not byte aligned, is reported bad (`frame_status` = 1).
- R10: Seven consecutive 1 bits set `hunt` to 1. If a frame was in progress, the frame is reported aborted (`frame_status` = 2) and the bytes still held back are discarded.
- R11: A pulse on `enter_hunt` sets `hunt` to 1 at the next edge, regardless of bit position. A frame in progress is reported aborted, and bytes already presented stay valid. Later bits produce nothing until a new flag arrives.
- R12: While `rx_en` is 0, `hunt` stays 1 and no byte or completion strobe is produced, whatever the line carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable; low holds the block in hunt and idle |
| bit_en | input | 1 | Bit-clock enable; `rx_bit` is sampled when high |
| rx_bit | input | 1 | Serial line data |
| enter_hunt | input | 1 | One-cycle command to drop flag sync |
| hunt | output | 1 | 1 while searching for a flag |
| byte_valid | output | 1 | Frame byte strobe |
| byte_data | output | 8 | Frame byte |
| byte_first | output | 1 | Byte is the address (first) byte |
| byte_last | output | 1 | Byte is the final data byte |
| frame_done | output | 1 | Frame completion strobe |
| frame_status | output | 2 | 0 good, 1 bad, 2 aborted; valid with `frame_done` |

## Verification
`hunt` follows the sampling edge of the bit that changes it, so the bench reads it at the falling edge right after that bit. Bytes and the completion strobe arrive one clock after the sampling edge of the bit that completes them. The bench logs the cycle number of every strobe it sees at falling edges and checks that `frame_done` lands exactly one cycle after the closing flag's last bit. It waits a few idle cycles after each stimulus before it compares captured bytes and status, so a strobe that is due never goes unseen.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  typedef enum logic [1:0] {
    FS_GOOD  = 2'd0,
    FS_BAD   = 2'd1,
    FS_ABORT = 2'd2
  } frm_status_e;

  localparam int          CRC_W            = 16;
  localparam int          FCS_OCTETS       = CRC_W / 8;
  localparam logic [15:0] CRC_PRESET       = 16'hFFFF;
  localparam logic [15:0] CRC_GOOD_RESIDUE = 16'hF0B8;
  localparam logic [15:0] CRC_POLY_REFL    = 16'h8408;

  // Reflected CRC-CCITT over one byte, least significant bit first.
  function automatic logic [15:0] crc_step_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/hdlc_rx_linecode.sv
// Line decoder: run-of-ones tracking, flag / abort detection, zero deletion,
// flag-sync (hunt) state. All outputs are registered pulses.
module hdlc_rx_linecode #(
  parameter int FLAG_RUN = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_en,
  input  logic bit_en,
  input  logic rx_bit,
  input  logic enter_hunt,
  output logic hunt,
  output logic bit_vld,
  output logic bit_val,
  output logic open_ev,
  output logic close_ev,
  output logic drop_ev
);

  localparam int ABORT_RUN = FLAG_RUN + 1;
  localparam int STUFF_RUN = FLAG_RUN - 1;
  localparam int RUN_W     = $clog2(ABORT_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_FLAG  = RUN_W'(FLAG_RUN);
  localparam logic [RUN_W-1:0] RUN_STUFF = RUN_W'(STUFF_RUN);
  localparam logic [RUN_W-1:0] RUN_MAX   = RUN_W'(ABORT_RUN);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    bit_vld  <= 1'b0;
    open_ev  <= 1'b0;
    close_ev <= 1'b0;
    drop_ev  <= 1'b0;
    if (rst || !rx_en) begin
      run_q   <= '0;
      hunt    <= 1'b1;
      bit_val <= 1'b0;
    end else begin
      if (bit_en) begin
        if (rx_bit) begin
          if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
        end else begin
          run_q <= '0;
        end
      end
      if (enter_hunt) begin
        drop_ev <= !hunt;
        hunt    <= 1'b1;
      end else if (bit_en) begin
        if (rx_bit) begin
          if (run_q == RUN_FLAG) begin
            drop_ev <= !hunt;
            hunt    <= 1'b1;
          end else if (!hunt) begin
            bit_vld <= 1'b1;
            bit_val <= 1'b1;
          end
        end else begin
          if (run_q == RUN_FLAG) begin
            if (hunt) begin
              open_ev <= 1'b1;
              hunt    <= 1'b0;
            end else begin
              close_ev <= 1'b1;
            end
          end else if (run_q != RUN_STUFF && !hunt) begin
            bit_vld <= 1'b1;
            bit_val <= 1'b0;
          end
        end
      end
    end
  end

  a_r1_single_event: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bit_vld, open_ev, close_ev, drop_ev}));

  a_r1_open_syncs: assert property (@(posedge clk) disable iff (rst)
    open_ev |-> !hunt);

  a_r2_no_data_in_hunt: assert property (@(posedge clk) disable iff (rst)
    bit_vld |-> !hunt);

  a_r10_drop_hunts: assert property (@(posedge clk) disable iff (rst)
    drop_ev |-> hunt);

  a_r11_cmd_hunts: assert property (@(posedge clk) disable iff (rst)
    (enter_hunt && rx_en) |=> hunt);

  a_r12_off_idle: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (hunt && !bit_vld && !open_ev && !close_ev));

endmodule

// File: rtl/hdlc_rx_fcs.sv
// Byte-wise CRC-CCITT accumulator with good-residue compare.
module hdlc_rx_fcs
  import hdlc_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       upd,
  input  logic [7:0] data,
  output logic       crc_ok
);

  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst || clr)  crc_q <= CRC_PRESET;
    else if (upd)    crc_q <= crc_step_byte(crc_q, data);
  end

  assign crc_ok = (crc_q == CRC_GOOD_RESIDUE);

endmodule

// File: rtl/hdlc_rx_assembler.sv
// Byte packing, check-octet holding line, frame markers and frame status.
module hdlc_rx_assembler
  import hdlc_rx_pkg::*;
#(
  parameter int FCS_BYTES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       bit_vld,
  input  logic       bit_val,
  input  logic       open_ev,
  input  logic       close_ev,
  input  logic       drop_ev,
  input  logic       crc_ok,
  output logic       push,
  output logic [7:0] push_byte,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic       byte_first,
  output logic       byte_last,
  output logic       frame_done,
  output logic [1:0] frame_status
);

  localparam int HOLD      = FCS_BYTES + 1;
  localparam int MIN_BYTES = FCS_BYTES + 2;
  localparam int CNT_W     = $clog2(MIN_BYTES + 1);
  localparam int HC_W      = $clog2(HOLD + 1);
  localparam int HI_W      = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CNT_W-1:0] CNT_MIN  = CNT_W'(MIN_BYTES);
  localparam logic [HC_W-1:0]  HC_FULL  = HC_W'(HOLD);

  logic [6:0]       sh;
  logic [2:0]       bcnt;
  logic [CNT_W-1:0] nbytes;
  logic [HC_W-1:0]  hcnt;
  logic [7:0]       hold [HOLD];
  logic             first_pend;
  logic             frame_edge;

  assign push       = bit_vld && (bcnt == 3'd7);
  assign push_byte  = {bit_val, sh};
  assign frame_edge = close_ev || drop_ev || open_ev;

  always_ff @(posedge clk) begin
    byte_valid <= 1'b0;
    byte_first <= 1'b0;
    byte_last  <= 1'b0;
    frame_done <= 1'b0;
    if (rst || clr) begin
      sh           <= '0;
      bcnt         <= '0;
      nbytes       <= '0;
      hcnt         <= '0;
      first_pend   <= 1'b1;
      byte_data    <= '0;
      frame_status <= FS_GOOD;
    end else if (frame_edge) begin
      if (nbytes != '0) begin
        frame_done <= 1'b1;
        if (drop_ev)
          frame_status <= FS_ABORT;
        else if (nbytes == CNT_MIN && bcnt == 3'd7 && crc_ok)
          frame_status <= FS_GOOD;
        else
          frame_status <= FS_BAD;
      end
      if (close_ev && hcnt == HC_FULL) begin
        byte_valid <= 1'b1;
        byte_data  <= hold[0];
        byte_first <= first_pend;
        byte_last  <= 1'b1;
      end
      bcnt       <= '0;
      nbytes     <= '0;
      hcnt       <= '0;
      first_pend <= 1'b1;
    end else if (bit_vld) begin
      sh   <= push_byte[7:1];
      bcnt <= bcnt + 3'd1;
      if (push) begin
        if (nbytes != CNT_MIN) nbytes <= nbytes + 1'b1;
        if (hcnt == HC_FULL) begin
          byte_valid <= 1'b1;
          byte_data  <= hold[0];
          byte_first <= first_pend;
          first_pend <= 1'b0;
          for (int i = 0; i < HOLD - 1; i++) hold[i] <= hold[i+1];
          hold[HOLD-1] <= push_byte;
        end else begin
          hold[hcnt[HI_W-1:0]] <= push_byte;
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end

  a_r4_last_has_valid: assert property (@(posedge clk) disable iff (rst)
    byte_last |-> byte_valid);

  a_r4_first_has_valid: assert property (@(posedge clk) disable iff (rst)
    byte_first |-> byte_valid);

  a_r5_status_legal: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (frame_status != 2'd3));

  a_r6_done_follows_edge: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> $past(frame_edge));

  a_r10_abort_no_bytes: assert property (@(posedge clk) disable iff (rst)
    (frame_done && frame_status == FS_ABORT) |-> !byte_valid);

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int FLAG_RUN = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_en,
  input  logic       bit_en,
  input  logic       rx_bit,
  input  logic       enter_hunt,
  output logic       hunt,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic       byte_first,
  output logic       byte_last,
  output logic       frame_done,
  output logic [1:0] frame_status
);

  localparam int FCS_BYTES = FCS_OCTETS;

  logic       lc_bit_vld, lc_bit_val, lc_open, lc_close, lc_drop;
  logic       as_push;
  logic [7:0] as_push_byte;
  logic       fcs_ok;
  logic       fcs_clr;

  hdlc_rx_linecode #(.FLAG_RUN(FLAG_RUN)) u_linecode (
    .clk        (clk),
    .rst        (rst),
    .rx_en      (rx_en),
    .bit_en     (bit_en),
    .rx_bit     (rx_bit),
    .enter_hunt (enter_hunt),
    .hunt       (hunt),
    .bit_vld    (lc_bit_vld),
    .bit_val    (lc_bit_val),
    .open_ev    (lc_open),
    .close_ev   (lc_close),
    .drop_ev    (lc_drop)
  );

  assign fcs_clr = lc_open || lc_close || lc_drop || !rx_en;

  hdlc_rx_fcs u_fcs (
    .clk    (clk),
    .rst    (rst),
    .clr    (fcs_clr),
    .upd    (as_push),
    .data   (as_push_byte),
    .crc_ok (fcs_ok)
  );

  hdlc_rx_assembler #(.FCS_BYTES(FCS_BYTES)) u_assembler (
    .clk          (clk),
    .rst          (rst),
    .clr          (!rx_en),
    .bit_vld      (lc_bit_vld),
    .bit_val      (lc_bit_val),
    .open_ev      (lc_open),
    .close_ev     (lc_close),
    .drop_ev      (lc_drop),
    .crc_ok       (fcs_ok),
    .push         (as_push),
    .push_byte    (as_push_byte),
    .byte_valid   (byte_valid),
    .byte_data    (byte_data),
    .byte_first   (byte_first),
    .byte_last    (byte_last),
    .frame_done   (frame_done),
    .frame_status (frame_status)
  );

endmodule

// File: tb/test_hdlc_rx_deframer.sv
`timescale 1ns/1ps
module test_hdlc_rx_deframer;

  logic clk = 1'b0, rst = 1'b1, rx_en = 1'b0, bit_en = 1'b0, rx_bit = 1'b1, enter_hunt = 1'b0;
  logic       hunt, byte_valid, byte_first, byte_last, frame_done;
  logic [7:0] byte_data;
  logic [1:0] frame_status;

  hdlc_rx_deframer i_hdlc_rx_deframer (
    .clk(clk), .rst(rst), .rx_en(rx_en), .bit_en(bit_en), .rx_bit(rx_bit),
    .enter_hunt(enter_hunt), .hunt(hunt), .byte_valid(byte_valid),
    .byte_data(byte_data), .byte_first(byte_first), .byte_last(byte_last),
    .frame_done(frame_done), .frame_status(frame_status)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, fails = 0;
  logic [7:0] got_d [64];
  logic       got_f [64];
  logic       got_l [64];
  int gn = 0, dn = 0, dcyc = 0;
  logic [1:0] dstat = 2'd3;

  always @(negedge clk) begin
    if (!rst) begin
      if (byte_valid && gn < 64) begin
        got_d[gn] = byte_data; got_f[gn] = byte_first; got_l[gn] = byte_last;
        gn++;
      end
      if (frame_done) begin
        dn++; dstat = frame_status; dcyc = cyc;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  int last_cyc = 0;
  int tx_ones = 0;
  logic [7:0] fb [16];

  task automatic send_raw(input logic b);
    @(negedge clk); rx_bit = b; bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0; last_cyc = cyc;
  endtask

  task automatic send_flag();
    for (int i = 0; i < 8; i++) send_raw((i == 0 || i == 7) ? 1'b0 : 1'b1);
    tx_ones = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      send_raw(b[i]);
      if (b[i]) tx_ones++; else tx_ones = 0;
      if (tx_ones == 5) begin send_raw(1'b0); tx_ones = 0; end
    end
  endtask

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++) begin
        logic fbk = c[0] ^ fb[k][i];
        c = c >> 1;
        if (fbk) c = c ^ 16'h8408;
      end
    return c;
  endfunction

  task automatic send_frame(input int n, input bit corrupt);
    logic [15:0] fcs = ~ref_crc(n);
    if (corrupt) fcs = fcs ^ 16'h0001;
    send_flag();
    for (int k = 0; k < n; k++) send_byte(fb[k]);
    send_byte(fcs[7:0]);
    send_byte(fcs[15:8]);
    send_flag();
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_bytes(input string tag, input int base, input int n);
    chk(gn == base + n, {tag, " byte count"}, gn - base, n);
    for (int k = 0; k < n; k++) begin
      if (base + k < 64) begin
        chk(got_d[base+k] == fb[k], {tag, " data"}, got_d[base+k], fb[k]);
        chk(got_f[base+k] == (k == 0), {tag, " first R4"}, got_f[base+k], k == 0);
        chk(got_l[base+k] == (k == n - 1), {tag, " last R4"}, got_l[base+k], k == n - 1);
      end
    end
  endtask

  task automatic t_reset();
    idle(2);
    chk(hunt == 1'b1, "R1 hunt at reset", hunt, 1);
    chk(byte_valid == 1'b0 && frame_done == 1'b0, "R1 idle outputs at reset",
        {byte_valid, frame_done}, 0);
    rst = 1'b0; rx_en = 1'b1; idle(2);
    for (int i = 0; i < 10; i++) send_raw(1'b1);
    chk(hunt == 1'b1, "R1 hunt before flag", hunt, 1);
    send_flag();
    chk(hunt == 1'b0, "R1 flag clears hunt", hunt, 0);
  endtask

  task automatic t_good();
    int base = gn, dbase = dn, lc;
    fb[0] = 8'h03; fb[1] = 8'hFF; fb[2] = 8'h7E; fb[3] = 8'h1F; fb[4] = 8'hF8;
    send_frame(5, 1'b0);
    lc = last_cyc;
    idle(4);
    chk(dn == dbase + 1, "R5 one completion", dn - dbase, 1);
    chk(dstat == 2'd0, "R5 good status", dstat, 0);
    chk(dcyc == lc + 1, "R6 completion timing", dcyc, lc + 1);
    check_bytes("R2 R3 good frame", base, 5);
    chk(hunt == 1'b0, "R1 sync kept after frame", hunt, 0);
  endtask

  task automatic t_flags();
    int base = gn, dbase = dn;
    send_flag(); send_flag(); send_flag();
    idle(4);
    chk(dn == dbase, "R7 no completion on flags", dn - dbase, 0);
    chk(gn == base, "R7 no bytes on flags", gn - base, 0);
  endtask

  task automatic t_badfcs();
    int base = gn, dbase = dn;
    fb[0] = 8'h21; fb[1] = 8'h43; fb[2] = 8'h65;
    send_frame(3, 1'b1);
    idle(4);
    chk(dn == dbase + 1 && dstat == 2'd1, "R8 bad check sequence", dstat, 1);
    check_bytes("R8 bytes kept", base, 3);
  endtask

  task automatic t_short();
    int base = gn, dbase = dn;
    send_flag(); send_byte(8'h11); send_byte(8'h22); send_flag();
    idle(4);
    chk(dn == dbase + 1 && dstat == 2'd1, "R9 short frame bad", dstat, 1);
    chk(gn == base, "R9 short frame no bytes", gn - base, 0);
  endtask

  task automatic t_misalign();
    int dbase = dn;
    logic [15:0] fcs;
    fb[0] = 8'h11; fb[1] = 8'h22;
    fcs = ~ref_crc(2);
    send_flag(); send_byte(fb[0]); send_byte(fb[1]);
    send_byte(fcs[7:0]); send_byte(fcs[15:8]);
    send_raw(1'b0); send_raw(1'b0); send_raw(1'b0);
    send_flag();
    idle(4);
    chk(dn == dbase + 1 && dstat == 2'd1, "R9 misaligned flag bad", dstat, 1);
  endtask

  task automatic t_abort();
    int base = gn, dbase = dn;
    fb[0] = 8'h12; fb[1] = 8'h34; fb[2] = 8'h56; fb[3] = 8'h70; fb[4] = 8'h01;
    send_flag();
    for (int k = 0; k < 5; k++) send_byte(fb[k]);
    for (int i = 0; i < 7; i++) send_raw(1'b1);
    chk(hunt == 1'b1, "R10 abort enters hunt", hunt, 1);
    idle(4);
    chk(dn == dbase + 1 && dstat == 2'd2, "R10 aborted status", dstat, 2);
    chk(gn == base + 2, "R10 held bytes dropped", gn - base, 2);
    chk(got_d[base] == 8'h12 && got_d[base+1] == 8'h34, "R10 delivered bytes",
        {got_d[base], got_d[base+1]}, 16'h1234);
  endtask

  task automatic t_hunt_cmd();
    int base = gn, dbase = dn;
    send_flag();
    for (int k = 0; k < 5; k++) send_byte(8'h11 * (k + 1));
    send_raw(1'b1); send_raw(1'b0); send_raw(1'b1);
    @(negedge clk); enter_hunt = 1'b1;
    @(negedge clk); enter_hunt = 1'b0;
    chk(hunt == 1'b1, "R11 hunt after command", hunt, 1);
    idle(3);
    chk(dn == dbase + 1 && dstat == 2'd2, "R11 aborted status", dstat, 2);
    chk(gn == base + 2 && got_d[base] == 8'h11 && got_d[base+1] == 8'h22,
        "R11 delivered bytes kept", gn - base, 2);
    send_byte(8'h00); send_byte(8'h5A); send_byte(8'h3C);
    idle(4);
    chk(gn == base + 2 && dn == dbase + 1 && hunt == 1'b1, "R11 bits ignored in hunt",
        gn - base, 2);
    fb[0] = 8'hC3; fb[1] = 8'h81; fb[2] = 8'h7F;
    base = gn; dbase = dn;
    send_frame(3, 1'b0);
    idle(4);
    chk(dn == dbase + 1 && dstat == 2'd0, "R11 recovery good frame", dstat, 0);
    check_bytes("R11 recovery", base, 3);
  endtask

  task automatic t_disabled();
    int base = gn, dbase = dn;
    @(negedge clk); rx_en = 1'b0;
    fb[0] = 8'h0F; fb[1] = 8'hF0; fb[2] = 8'hAA;
    send_flag();
    chk(hunt == 1'b1, "R12 hunt held when disabled", hunt, 1);
    send_frame(3, 1'b0);
    idle(4);
    chk(gn == base && dn == dbase, "R12 no output when disabled", (gn - base) + (dn - dbase), 0);
    @(negedge clk); rx_en = 1'b1;
    idle(2);
    chk(hunt == 1'b1, "R12 hunt after re-enable", hunt, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL R1 watchdog expired actual %0d expected below %0d cycles", cyc, 150000);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_reset();
    t_good();
    t_flags();
    t_badfcs();
    t_short();
    t_misalign();
    t_abort();
    t_hunt_cmd();
    t_disabled();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule